// File: doc/BRIEF.md
# Ripple-Carry Arithmetic and Logic Unit with Signed Overflow Flag

This block is a parameterized arithmetic and logic unit of WIDTH bits, assembled from WIDTH identical one-bit cells chained through their carries. Every cell contains a full adder, a two-input AND and an inverter. A two-bit operation code steers a four-way selector in each cell to choose which of these drives that cell's result bit. A separate subtract control turns the adder chain into a subtractor. It does this by inverting every Y bit and feeding a 1 into the carry of bit 0, so no second adder is needed.

The result word, the carry out of the top cell and a two's-complement overflow flag are registered once, so they appear on the clock edge after the operands are applied. The overflow flag looks only at three bits: the sign of X, the sign of the effective Y (after the subtract inversion) and the sign of the result. It is a status output only. It is forced low for logic operations, and so is the carry.

Top module: `alu_ripple`

## Requirements
- R1: While rst_n is low, z_o, carry_o and ovf_o are all 0.
- R2: With op_i = 2'b10 and sub_i = 0, the outputs change one clock edge after the inputs are applied. z_o = (x_i + y_i) mod 2^WIDTH, and carry_o is bit WIDTH of the unsigned sum.
- R3: With op_i = 2'b10 and sub_i = 1, z_o = (x_i + ~y_i + 1) mod 2^WIDTH, and carry_o is bit WIDTH of that unsigned sum. This makes carry_o 1 exactly when x_i >= y_i as unsigned values.
- R4: In addition, ovf_o is 1 exactly when the signed sum of x_i and y_i lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R5: In subtraction, ovf_o is 1 exactly when the signed difference x_i - y_i lies outside that same range.
- R6: When the sign of x_i differs from the sign of the effective second operand (y_i's sign XOR sub_i), ovf_o is 0.
- R7: With op_i = 2'b00, z_o = x_i AND y_i, and carry_o = ovf_o = 0, whatever sub_i is.
- R8: With op_i = 2'b01, z_o = NOT x_i and carry_o = ovf_o = 0. Neither y_i nor sub_i has any effect.
- R9: With op_i = 2'b11 (reserved), z_o = 0 and carry_o = ovf_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Operation code: 00 AND, 01 NOT X, 10 add/subtract, 11 reserved |
| sub_i | input | 1 | Subtract control for op 10 |
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand |
| z_o | output | WIDTH | Registered result |
| carry_o | output | 1 | Registered carry from the top cell (arithmetic only) |
| ovf_o | output | 1 | Registered two's-complement overflow (arithmetic only) |

## Verification
Addition and subtraction are each tried with seeded random operands, and then with every pairing of the extreme values, 0, 1 and -1. The random pairs confirm that the carry ripples correctly through all cells. The extreme pairings separate the true overflow cases from the same-sign cases that only come close to the range limit. They also catch an overflow rule that uses the raw Y sign instead of the inverted one during subtraction, because the most negative value minus 1 must overflow while the most negative value plus 1 must not. The logic and reserved codes are run with sub_i toggled and with operands whose sum would carry, which shows that the selector, not the adder, drives the result and that both flags stay low.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_AND   = 2'b00,
        OP_NOTX  = 2'b01,
        OP_ARITH = 2'b10,
        OP_RSVD  = 2'b11
    } alu_op_e;

endpackage

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
    import alu_pkg::*;
(
    input  logic    x_i,
    input  logic    y_i,
    input  logic    sub_i,
    input  logic    cin_i,
    input  alu_op_e op_i,
    output logic    res_o,
    output logic    cout_o
);

    logic y_eff;
    logic half;
    logic sum;

    always_comb begin
        y_eff  = y_i ^ sub_i;
        half   = x_i ^ y_eff;
        sum    = half ^ cin_i;
        cout_o = (x_i & y_eff) | (cin_i & half);
        unique case (op_i)
            OP_AND:   res_o = x_i & y_i;
            OP_NOTX:  res_o = ~x_i;
            OP_ARITH: res_o = sum;
            default:  res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_ovf_detect.sv
module alu_ovf_detect (
    input  logic en_i,
    input  logic x_sign_i,
    input  logic y_sign_i,
    input  logic z_sign_i,
    output logic ovf_o
);

    always_comb begin
        ovf_o = en_i & ((~x_sign_i & ~y_sign_i & z_sign_i) |
                        ( x_sign_i &  y_sign_i & ~z_sign_i));
    end

endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_i,
    input  logic             sub_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic [WIDTH-1:0] z_o,
    output logic             carry_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] z;
        logic             carry;
        logic             ovf;
    } alu_out_t;

    alu_op_e          op_sel;
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] cell_res;
    logic             is_arith;
    logic             ovf_raw;
    alu_out_t         out_d;
    alu_out_t         out_q;

    assign op_sel   = alu_op_e'(op_i);
    assign is_arith = (op_sel == OP_ARITH);
    assign chain[0] = sub_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        alu_bit_cell u_cell (
            .x_i    (x_i[i]),
            .y_i    (y_i[i]),
            .sub_i  (sub_i),
            .cin_i  (chain[i]),
            .op_i   (op_sel),
            .res_o  (cell_res[i]),
            .cout_o (chain[i+1])
        );
    end

    alu_ovf_detect u_ovf (
        .en_i     (is_arith),
        .x_sign_i (x_i[MSB]),
        .y_sign_i (y_i[MSB] ^ sub_i),
        .z_sign_i (cell_res[MSB]),
        .ovf_o    (ovf_raw)
    );

    always_comb begin
        out_d       = out_q;
        out_d.z     = cell_res;
        out_d.carry = is_arith & chain[WIDTH];
        out_d.ovf   = ovf_raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign z_o     = out_q.z;
    assign carry_o = out_q.carry;
    assign ovf_o   = out_q.ovf;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !$past(rst_n) |-> (z_o == '0 && !carry_o && !ovf_o)); // R1

    AST_ARITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'b10) |->
        ({carry_o, z_o} == ({1'b0, $past(x_i)} +
                            {1'b0, ($past(y_i) ^ {WIDTH{$past(sub_i)}})} +
                            {{WIDTH{1'b0}}, $past(sub_i)}))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'b10 &&
         ($past(x_i[MSB]) != ($past(y_i[MSB]) ^ $past(sub_i)))) |-> !ovf_o); // R6

    AST_AND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'b00) |->
        (z_o == ($past(x_i) & $past(y_i)) && !carry_o && !ovf_o)); // R7

    AST_NOT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'b01) |->
        (z_o == ~$past(x_i) && !carry_o && !ovf_o)); // R8

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 2'b11) |->
        (z_o == '0 && !carry_o && !ovf_o)); // R9

endmodule

// File: tb/tb_alu_ripple.sv
module tb_alu_ripple;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   op_i = 2'b00;
    logic         sub_i = 1'b0;
    logic [W-1:0] x_i = '0;
    logic [W-1:0] y_i = '0;
    logic [W-1:0] z_o;
    logic         carry_o;
    logic         ovf_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    alu_ripple #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .sub_i(sub_i),
        .x_i(x_i), .y_i(y_i), .z_o(z_o), .carry_o(carry_o), .ovf_o(ovf_o)
    );

    task automatic check(input string tag, input logic [W+1:0] got, input logic [W+1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got {carry,ovf,z}=%h expected %h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge register, sample at the next falling edge.
    task automatic apply(input logic [1:0] op, input logic sub, input logic [W-1:0] x, input logic [W-1:0] y);
        @(negedge clk);
        op_i = op; sub_i = sub; x_i = x; y_i = y;
        @(negedge clk);
    endtask

    function automatic logic [W+1:0] ref_arith(input logic sub, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W:0] full;
        int sx, sy, s;
        logic ov;
        sx = int'($signed(x));
        sy = int'($signed(y));
        if (sub) begin
            full = {1'b0, x} + {1'b0, ~y} + 1;
            s = sx - sy;
        end else begin
            full = {1'b0, x} + {1'b0, y};
            s = sx + sy;
        end
        ov = (s > 127) || (s < -128);
        return {full[W], ov, full[W-1:0]};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        op_i = 2'b10; x_i = 8'h7F; y_i = 8'h01;
        @(negedge clk);
        check("R1 reset", {carry_o, ovf_o, z_o}, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_add_random();
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a, b;
            a = W'($urandom); b = W'($urandom);
            apply(2'b10, 1'b0, a, b);
            check("R2/R4 add", {carry_o, ovf_o, z_o}, ref_arith(1'b0, a, b));
        end
    endtask

    task automatic t_sub_random();
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a, b;
            a = W'($urandom); b = W'($urandom);
            apply(2'b10, 1'b1, a, b);
            check("R3/R5 sub", {carry_o, ovf_o, z_o}, ref_arith(1'b1, a, b));
        end
    endtask

    task automatic t_corners();
        logic [W-1:0] v [5] = '{8'h80, 8'h7F, 8'h00, 8'h01, 8'hFF};
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                apply(2'b10, 1'b0, v[i], v[j]);
                check("R4 add corner", {carry_o, ovf_o, z_o}, ref_arith(1'b0, v[i], v[j]));
                apply(2'b10, 1'b1, v[i], v[j]);
                check("R5 sub corner", {carry_o, ovf_o, z_o}, ref_arith(1'b1, v[i], v[j]));
            end
        end
        apply(2'b10, 1'b0, 8'h7F, 8'h01);
        check("R4 max+1 overflows", {carry_o, ovf_o, z_o}, {1'b0, 1'b1, 8'h80});
        apply(2'b10, 1'b1, 8'h80, 8'h01);
        check("R5 min-1 overflows", {carry_o, ovf_o, z_o}, {1'b1, 1'b1, 8'h7F});
        apply(2'b10, 1'b0, 8'h80, 8'h7F);
        check("R6 opposite signs add", {carry_o, ovf_o, z_o}, {1'b0, 1'b0, 8'hFF});
        apply(2'b10, 1'b1, 8'h80, 8'h80);
        check("R6 same raw signs sub", {carry_o, ovf_o, z_o}, {1'b1, 1'b0, 8'h00});
    endtask

    task automatic t_logic();
        for (int i = 0; i < 12; i++) begin
            logic [W-1:0] a, b;
            logic s;
            a = W'($urandom); b = W'($urandom); s = i[0];
            apply(2'b00, s, a, b);
            check("R7 and", {carry_o, ovf_o, z_o}, {2'b00, a & b});
            apply(2'b01, s, a, b);
            check("R8 not", {carry_o, ovf_o, z_o}, {2'b00, ~a});
        end
        apply(2'b00, 1'b1, 8'hFF, 8'hFF);
        check("R7 and no flags", {carry_o, ovf_o, z_o}, {2'b00, 8'hFF});
        apply(2'b01, 1'b1, 8'h7F, 8'h7F);
        check("R8 not ignores y/sub", {carry_o, ovf_o, z_o}, {2'b00, 8'h80});
    endtask

    task automatic t_reserved();
        apply(2'b11, 1'b0, 8'h7F, 8'h7F);
        check("R9 reserved", {carry_o, ovf_o, z_o}, '0);
        apply(2'b11, 1'b1, 8'hFF, 8'h01);
        check("R9 reserved sub", {carry_o, ovf_o, z_o}, '0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        t_reset();
        t_add_random();
        t_sub_random();
        t_corners();
        t_logic();
        t_reserved();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule